// File: doc/BRIEF.md
# Command-Framed Serial Slave Interface

This block is the slave side of a three-wire serial control bus for a line-audio codec. The wires are an active-low select, a bus clock driven by the master, and one data line. The data line reaches the block as a separate input, output and output-enable, and the pad joins them. Every byte is framed by its own select pulse and moves most significant bit first. The block takes in data on the rising bus clock edge. It changes its outgoing bit only after a falling edge. The bus clock may idle at either level between selects, or it may keep running.

The first byte after reset, or after a command has run its course, is a command. A small decode table fixes each command's data byte count, its direction and its starting register. A write command stores the bytes that follow in consecutive registers. A read command returns consecutive registers, and the revision command returns a fixed code. Until the data bytes of a command are done, nothing that arrives is taken as a new command. A select that holds sixteen clock edges resets the command state. A select that comes too soon after the previous one is thrown away.

All three bus pins are synchronized into the system clock domain and their edges are detected there. The bus clock must therefore be slow compared with the system clock.

Top module: `cfs_slave`

## Requirements
- R1: A byte is accepted only when exactly 8 rising bus-clock edges occur within one select; it is assembled MSB first from `sdi` sampled at those edges. A select with any other count below 16 leaves all state unchanged.
- R2: The command table is: 73h reads 1 byte, the constant `REV_CODE`. 84h writes 15 bytes to registers 0..14. 85h reads 15 bytes from registers 0..14. 50h writes 2 bytes to registers 16..17. 51h reads 2 bytes from registers 16..17.
- R3: Any other command code has zero data bytes, so the next accepted byte is taken as a command.
- R4: Data bytes of a write command go to consecutive registers from the command's base. Data bytes of a read command return consecutive registers from the same base.
- R5: Until all data bytes of a command are transferred, no byte is decoded as a command. During read data bytes the value on `sdi` is ignored.
- R6: In a read byte, `sdo` carries bit 7 from the start of the select. It advances one bit after each falling bus-clock edge that follows a rising edge of that select. A falling edge before the first rising edge has no effect.
- R7: `sdo_oe` is high only while selected during a read data byte of a valid select. It drops within a few system cycles of the select ending. It stays low during command bytes and write data bytes.
- R8: The 16th rising bus-clock edge within one select resets the device. It discards the byte, clears the command state so that the next byte is a command, drops `sdo_oe`, and ignores the rest of that select. Register contents are kept.
- R9: A select that begins fewer than `MIN_OFF_CYC` system cycles after the previous select ended is ignored entirely: no byte, no reset, and `sdo_oe` stays low.
- R10: Bus-clock edges while deselected have no effect.
- R11: Synchronous reset leaves `sdo_oe` low and the block waiting for a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Bus clock from the master, asynchronous |
| cs_n | input | 1 | Active-low select, asynchronous |
| sdi | input | 1 | Serial data from the pad |
| sdo | output | 1 | Serial data to the pad |
| sdo_oe | output | 1 | Pad output enable for `sdo` |

## Verification
The assertions assume that every level on `cs_n`, `sclk` and `sdi` lasts several system cycles, so that each bus edge is seen exactly once after synchronization. They also assume that `sdi` is stable around the rising bus-clock edge and that select edges do not coincide with bus-clock edges. The stimulus keeps each bus-clock half period at 16 system cycles and changes `sdi` half a period before the rising edge. It keeps at least four idle cycles between a select edge and any bus-clock edge, and it runs the off-time cases well above or well below the threshold.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  localparam int BYTE_W = 8;
  localparam int LEN_W  = 4;
  localparam int BASE_W = 5;

  typedef struct packed {
    logic              rd;
    logic              fixed_src;
    logic [LEN_W-1:0]  len;
    logic [BASE_W-1:0] base;
  } cmd_info_t;

  function automatic cmd_info_t decode_cmd(input logic [BYTE_W-1:0] code);
    cmd_info_t d;
    d = '0;
    case (code)
      8'h73: begin d.rd = 1'b1; d.fixed_src = 1'b1; d.len = 4'd1;  end
      8'h84: begin d.len = 4'd15; d.base = 5'd0; end
      8'h85: begin d.rd = 1'b1; d.len = 4'd15; d.base = 5'd0; end
      8'h50: begin d.len = 4'd2;  d.base = 5'd16; end
      8'h51: begin d.rd = 1'b1; d.len = 4'd2;  d.base = 5'd16; end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cfs_sync.sv
module cfs_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);

  logic [STAGES-1:0][N-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= din;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/cfs_framer.sv
module cfs_framer #(
  parameter int BYTE_BITS   = 8,
  parameter int CLK_LIMIT   = 16,
  parameter int MIN_OFF_CYC = 320
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 sck,
  input  logic                 din,
  output logic                 byte_valid,
  output logic [BYTE_BITS-1:0] byte_data,
  output logic                 dev_reset,
  output logic                 sel_start,
  output logic                 tx_shift
);

  localparam int CNT_W = $clog2(CLK_LIMIT + 1);
  localparam int OFF_W = $clog2(MIN_OFF_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(CLK_LIMIT - 1);
  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_BITS);
  localparam logic [OFF_W-1:0] OFF_SAT   = OFF_W'(MIN_OFF_CYC);

  logic             sel_d, sck_d;
  logic             sel_begin, sel_end, sck_rise, sck_fall;
  logic             live;
  logic [CNT_W-1:0] edges;
  logic [OFF_W-1:0] off_cnt;

  assign sel_begin = sel & ~sel_d;
  assign sel_end   = ~sel & sel_d;
  assign sck_rise  = sck & ~sck_d;
  assign sck_fall  = ~sck & sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d      <= 1'b0;
      sck_d      <= 1'b0;
      live       <= 1'b0;
      edges      <= '0;
      off_cnt    <= OFF_SAT;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      dev_reset  <= 1'b0;
      sel_start  <= 1'b0;
      tx_shift   <= 1'b0;
    end else begin
      sel_d      <= sel;
      sck_d      <= sck;
      byte_valid <= 1'b0;
      dev_reset  <= 1'b0;
      sel_start  <= 1'b0;
      tx_shift   <= 1'b0;

      if (!sel && off_cnt != OFF_SAT) off_cnt <= off_cnt + 1'b1;

      if (sel_begin) begin
        live      <= (off_cnt == OFF_SAT);
        sel_start <= (off_cnt == OFF_SAT);
        edges     <= '0;
      end else if (sel && live && sck_rise) begin
        byte_data <= {byte_data[BYTE_BITS-2:0], din};
        if (edges == LAST_EDGE) begin
          dev_reset <= 1'b1;
          live      <= 1'b0;
          edges     <= '0;
        end else begin
          edges <= edges + 1'b1;
        end
      end else if (sel && live && sck_fall && edges != '0) begin
        tx_shift <= 1'b1;
      end

      if (sel_end) begin
        off_cnt <= '0;
        live    <= 1'b0;
        if (live && edges == FULL_BYTE) byte_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfs_seq.sv
module cfs_seq
  import cfs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_reset,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [LEN_W-1:0]  rem,
  output logic              cmd_rd,
  output logic              fixed_src,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);

  cmd_info_t info;
  assign info = decode_cmd(byte_data);

  always_ff @(posedge clk) begin
    if (rst || dev_reset) begin
      rem       <= '0;
      cmd_rd    <= 1'b0;
      fixed_src <= 1'b0;
      addr      <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (byte_valid) begin
        if (rem == '0) begin
          rem       <= info.len;
          cmd_rd    <= info.rd;
          fixed_src <= info.fixed_src;
          addr      <= ADDR_W'(info.base);
        end else begin
          rem  <= rem - 1'b1;
          addr <= addr + 1'b1;
          if (!cmd_rd) begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= byte_data;
          end
        end
      end
    end
  end

endmodule

// File: rtl/cfs_regfile.sv
module cfs_regfile #(
  parameter int DW     = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cfs_slave.sv
module cfs_slave
  import cfs_pkg::*;
#(
  parameter int              ADDR_W      = 5,
  parameter int              MIN_OFF_CYC = 320,
  parameter int              CLK_LIMIT   = 16,
  parameter int              SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] REV_CODE  = 8'h2C
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0]  raw, syn;
  logic              byte_valid, dev_reset, sel_start, tx_shift;
  logic [BYTE_W-1:0] byte_data;
  logic [LEN_W-1:0]  rem;
  logic              cmd_rd, fixed_src, rd_phase;
  logic [ADDR_W-1:0] addr, wr_addr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [BYTE_W-1:0] tx_sr;
  logic              tx_act;

  assign raw = {sdi, sclk, ~cs_n};

  cfs_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .q(syn)
  );

  cfs_framer #(.BYTE_BITS(BYTE_W), .CLK_LIMIT(CLK_LIMIT), .MIN_OFF_CYC(MIN_OFF_CYC)) u_framer (
    .clk(clk), .rst(rst), .sel(syn[0]), .sck(syn[1]), .din(syn[2]),
    .byte_valid(byte_valid), .byte_data(byte_data), .dev_reset(dev_reset),
    .sel_start(sel_start), .tx_shift(tx_shift)
  );

  cfs_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .dev_reset(dev_reset), .byte_valid(byte_valid),
    .byte_data(byte_data), .rem(rem), .cmd_rd(cmd_rd), .fixed_src(fixed_src),
    .addr(addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  cfs_regfile #(.DW(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(addr), .rdata(rd_data)
  );

  assign rd_phase = (rem != '0) && cmd_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr  <= '0;
      tx_act <= 1'b0;
    end else begin
      if (sel_start && rd_phase) begin
        tx_sr  <= fixed_src ? REV_CODE : rd_data;
        tx_act <= 1'b1;
      end else if (tx_shift && tx_act) begin
        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
      end
      if (!syn[0] || dev_reset) tx_act <= 1'b0;
    end
  end

  assign sdo    = tx_sr[BYTE_W-1];
  assign sdo_oe = tx_act;

endmodule

// File: rtl/cfs_slave_chk.sv
module cfs_slave_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             sdo_oe,
  input logic             byte_valid,
  input logic             dev_reset,
  input logic [LEN_W-1:0] rem,
  input logic             rd_phase
);

  logic [7:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (!cs_n) hi_run <= '0;
    else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
  end

  AST_IDLE_OE_LOW: assert property (@(posedge clk) disable iff (rst)
    (hi_run >= 8'(SYNC_STAGES + 2)) |-> !sdo_oe);                       // R7

  AST_OE_READ_PHASE: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> rd_phase);                                               // R7

  AST_DATA_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && rem != '0) |=> (rem == $past(rem) - 1'b1));          // R5

  AST_RESET_CLEARS_CMD: assert property (@(posedge clk) disable iff (rst)
    dev_reset |=> (rem == '0));                                         // R8

  AST_RESET_DROPS_OE: assert property (@(posedge clk) disable iff (rst)
    dev_reset |=> !sdo_oe);                                             // R8

  AST_POR_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sdo_oe && rem == '0));                             // R11

endmodule

bind cfs_slave cfs_slave_chk #(.SYNC_STAGES(SYNC_STAGES), .LEN_W(cfs_pkg::LEN_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdo_oe(sdo_oe), .byte_valid(byte_valid),
  .dev_reset(dev_reset), .rem(rem), .rd_phase(rd_phase)
);

// File: tb/test_cfs_slave.sv
module test_cfs_slave;

  localparam int HALF      = 16;
  localparam int MIN_OFF   = 320;
  localparam int GAP_OK    = 340;
  localparam int GAP_SHORT = 60;
  localparam logic [7:0] REV = 8'h2C;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;

  int compared = 0, mismatched = 0, settle = 0;
  bit exp_oe = 1'b0;
  bit done = 1'b0;

  int m_rem = 0, m_addr = 0;
  bit m_rd = 1'b0, m_rev = 1'b0;
  logic [7:0] mem [32];

  always #4 clk = ~clk;

  cfs_slave #(.ADDR_W(5), .MIN_OFF_CYC(MIN_OFF), .CLK_LIMIT(16), .SYNC_STAGES(2),
              .REV_CODE(REV)) i_cfs_slave (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one system cycle; output enable compared against the model on every clock (R7)
  task automatic step();
    @(negedge clk);
    if (settle > 0) settle--;
    else check(sdo_oe === exp_oe, "R7", "sdo_oe per cycle", int'(sdo_oe), int'(exp_oe));
  endtask

  function automatic void model_update(input logic [7:0] tx, input int nclk, input bit ok);
    if (!ok) return;
    if (nclk >= 16) begin m_rem = 0; return; end
    if (nclk != 8) return;
    if (m_rem == 0) begin
      m_rd = 1'b0; m_rev = 1'b0; m_addr = 0;
      case (tx)
        8'h73: begin m_rd = 1'b1; m_rev = 1'b1; m_rem = 1; end
        8'h84: m_rem = 15;
        8'h85: begin m_rd = 1'b1; m_rem = 15; end
        8'h50: begin m_rem = 2; m_addr = 16; end
        8'h51: begin m_rd = 1'b1; m_rem = 2; m_addr = 16; end
        default: m_rem = 0;
      endcase
    end else begin
      if (!m_rd) mem[m_addr] = tx;
      m_addr++;
      m_rem--;
    end
  endfunction

  task automatic send(input logic [7:0] tx, input int nclk, input int gap,
                      input bit idle_hi, input bit free_run, input string req);
    logic [7:0] rx, exp_rx;
    bit ok_gap, rd_data;
    ok_gap  = gap > MIN_OFF;
    rd_data = ok_gap && m_rem > 0 && m_rd;
    exp_rx  = m_rev ? REV : mem[m_addr];
    for (int i = 0; i < gap; i++) begin
      step();
      if (free_run && (i % 8) == 7) sclk = ~sclk;   // R10 edges while deselected
    end
    sclk = idle_hi;
    repeat (4) step();
    cs_n = 1'b0; exp_oe = rd_data; settle = 8;
    repeat (12) step();
    rx = '0;
    for (int b = 0; b < nclk; b++) begin
      if (idle_hi) sclk = 1'b0;
      sdi = (b < 8) ? tx[7-b] : 1'b0;
      repeat (HALF) step();
      rx = {rx[6:0], sdo};
      sclk = 1'b1;
      if (b == 15) begin exp_oe = 1'b0; settle = 8; end
      repeat (HALF) step();
      if (!idle_hi) sclk = 1'b0;
    end
    repeat (HALF) step();
    cs_n = 1'b1; exp_oe = 1'b0; settle = 8;
    if (rd_data && nclk == 8) check(rx === exp_rx, req, "read byte", int'(rx), int'(exp_rx));
    model_update(tx, nclk, ok_gap);
  endtask

  task automatic wb(input logic [7:0] tx, input string req);
    send(tx, 8, GAP_OK, 1'b0, 1'b0, req);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    check(sdo_oe === 1'b0, "R11", "oe in reset", int'(sdo_oe), 0);
    rst = 1'b0;
    repeat (5) step();
    check(sdo_oe === 1'b0, "R11", "oe after reset", int'(sdo_oe), 0);

    // R11 / R2: first byte is a command; revision read
    wb(8'h73, "R2"); wb(8'h00, "R2 R11 revision");

    // R2 R4: two-byte block
    wb(8'h50, "R4"); wb(8'h1E, "R4"); wb(8'hA7, "R4");
    wb(8'h51, "R4"); wb(8'h00, "R4 r16"); wb(8'h00, "R4 r17");

    // R4: fifteen-byte block write
    wb(8'h84, "R4");
    for (int i = 0; i < 15; i++) wb(8'((i * 37 + 5) & 8'hFF), "R4");
    // R5 R6: read back with idle-high clock, sdi carrying a command code
    wb(8'h85, "R5");
    for (int i = 0; i < 15; i++) send(8'h73, 8, GAP_OK, 1'b1, 1'b0, "R5 R6 block read");

    // R3: unknown code has no data bytes
    wb(8'h99, "R3"); wb(8'h51, "R3"); wb(8'h00, "R3 r16"); wb(8'h00, "R3 r17");

    // R1: 5 and 15 clock selects discarded
    wb(8'h50, "R1");
    send(8'h11, 5, GAP_OK, 1'b0, 1'b0, "R1");
    wb(8'h22, "R1");
    send(8'h44, 15, GAP_OK, 1'b0, 1'b0, "R1");
    wb(8'h33, "R1");
    wb(8'h51, "R1"); wb(8'h00, "R1 r16"); wb(8'h00, "R1 r17");

    // R8: 16 clocks mid write
    wb(8'h84, "R8"); wb(8'h01, "R8"); wb(8'h02, "R8");
    send(8'hFF, 16, GAP_OK, 1'b0, 1'b0, "R8");
    wb(8'h73, "R8"); wb(8'h00, "R8 cmd after reset");
    wb(8'h85, "R8");
    for (int i = 0; i < 15; i++) wb(8'h00, "R8 registers kept");

    // R8: 16 clocks mid read, oe drops (per-cycle compare)
    wb(8'h85, "R8"); wb(8'h00, "R8");
    send(8'h00, 16, GAP_OK, 1'b0, 1'b0, "R8");
    wb(8'h51, "R8"); wb(8'h00, "R8 read after reset"); wb(8'h00, "R8 read after reset");

    // R9: short off time during write and during read
    wb(8'h50, "R9");
    wb(8'hC4, "R9");
    send(8'h77, 8, GAP_SHORT, 1'b0, 1'b0, "R9");
    wb(8'h5B, "R9");
    wb(8'h51, "R9");
    send(8'h00, 8, GAP_SHORT, 1'b0, 1'b0, "R9");
    wb(8'h00, "R9 r16"); wb(8'h00, "R9 r17");

    // R10: clock running between selects
    send(8'h50, 8, GAP_OK, 1'b0, 1'b1, "R10");
    send(8'h5A, 8, GAP_OK, 1'b0, 1'b1, "R10");
    send(8'h0F, 8, GAP_OK, 1'b1, 1'b1, "R10");
    wb(8'h51, "R10"); wb(8'h00, "R10 r16"); wb(8'h00, "R10 r17");

    repeat (20) step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule